// File: doc/BRIEF.md
# Multicore Test Access Hub

The hub connects one chip-level test port to a parameterised number of identical cores, each of which has its own serial test path. The chip-level TAP controller is outside the hub. It supplies the decoded data-register strobes (capture, shift, update), a synchronous test-logic-reset strobe and an instruction select. That select routes scan traffic either into the hub's own configuration register or out to the cores. The configuration register holds three things: the operating mode, a per-core enable mask and the index of a reference core.

In serial mode the enabled cores form one daisy chain between the chip test input and the chip test output. Each disabled core is replaced by a single bypass stage, so the chain keeps working whatever the mask. In concurrent mode every enabled core receives the same test input. The chip test output then follows the reference core.

Each core's output stream is compressed into a 16-bit signature. The feedback polynomial is x^16+x^12+x^5+1, and the signature is seeded to zero when a test starts. On update, each enabled core's signature is compared with the reference core's signature. A mismatch sets a sticky per-core fail flag. The same logic serves any core count, from one upward.

Top module: `mctap_hub`

## Requirements
- R1: After reset, `core_fail` is all zero. The configuration word is serial mode, all cores enabled and reference index 0.
- R2: The configuration word is selected by `sel_cfg`. On capture it loads its current value. On shift it moves toward bit 0, with `tdo` showing bit 0 and `tdi` entering the top bit. On update the shifted word takes effect. Layout: bit 0 is the mode (0 serial, 1 concurrent), bits 1..N are the enable mask (bit 1+i for core i), and the bits above those are the reference index.
- R3: In serial mode the chain runs from `tdi` through core 0, then core 1 and on to core N-1, ending at `tdo`. An enabled core adds its own path length. Enabled cores receive `core_capture` and `core_shift` whenever a data scan captures or shifts.
- R4: In serial mode a disabled core adds exactly one stage. That stage loads 0 on capture and shifts on each shift cycle.
- R5: In concurrent mode every `core_tdi` carries `tdi`, and `tdo` carries the reference core's `core_tdo`.
- R6: On update in concurrent mode, an enabled core whose signature differs from the reference signature sets its `core_fail` bit. The bit stays set through later tests.
- R7: A disabled core never has its fail bit set, and its capture and shift strobes stay low.
- R8: The `tlr` strobe clears every fail bit and returns the configuration word to its reset value.
- R9: Signatures restart from zero on each concurrent capture, so a clean test that follows a faulty one compares equal.
- R10: An update in serial mode leaves the fail bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Test-logic-reset strobe from the chip controller |
| sel_cfg | input | 1 | Instruction select: 1 routes scans into the configuration word |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Chip test data in |
| tdo | output | 1 | Chip test data out |
| core_tdi | output | N_CORES | Serial data into each core |
| core_shift | output | N_CORES | Per-core shift strobe |
| core_capture | output | N_CORES | Per-core capture strobe |
| core_tdo | input | N_CORES | Serial data out of each core |
| core_fail | output | N_CORES | Sticky per-core compare failure |

## Verification
The serial chain is scanned with three enable masks: all cores, alternate cores and none. The delay before the shifted pattern reappears, and the zeros that lead it out, tell an enabled core apart from a bypass stage and show the chain order.

Concurrent scans are run with no fault, then with an inverted output on a non-reference core, then with that fault on the chosen reference, and finally with a fault on a disabled core. These cases separate reference selection, the stickiness of the fail flags and the exclusion of masked cores.

A faulty concurrent test, then a reset strobe, then a clean test shows whether the signatures are reseeded. A serial update with a faulty core shows that the comparison is confined to concurrent mode.

// File: rtl/mctap_pkg.sv
package mctap_pkg;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_CONC   = 1'b1
  } mctap_mode_e;

  localparam int unsigned SIG_W = 16;
  // x^16 + x^12 + x^5 + 1, top term implied
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;

  function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] cur,
                                                input logic din);
    logic fb;
    fb = cur[SIG_W-1] ^ din;
    return {cur[SIG_W-2:0], 1'b0} ^ ({SIG_W{fb}} & SIG_POLY);
  endfunction

endpackage

// File: rtl/mctap_cfg.sv
module mctap_cfg
  import mctap_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tlr,
  input  logic               sel_cfg,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               tdi,
  output logic               tdo_cfg,
  output mctap_mode_e        mode,
  output logic [N_CORES-1:0] en,
  output logic [IDX_W-1:0]   ref_idx
);

  localparam int unsigned CW = 1 + N_CORES + IDX_W;
  localparam logic [CW-1:0] CFG_RST = {{IDX_W{1'b0}}, {N_CORES{1'b1}}, 1'b0};

  logic [CW-1:0]    sh_q, sh_d;
  logic [CW-1:0]    cfg_q, cfg_d;
  logic [IDX_W-1:0] ref_fld;

  always_comb begin
    sh_d  = sh_q;
    cfg_d = cfg_q;
    if (tlr) begin
      cfg_d = CFG_RST;
    end else if (sel_cfg) begin
      if (capture_dr)      sh_d  = cfg_q;
      else if (shift_dr)   sh_d  = {tdi, sh_q[CW-1:1]};
      if (update_dr)       cfg_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cfg_q <= CFG_RST;
    end else begin
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
    end
  end

  assign tdo_cfg = sh_q[0];
  assign mode    = mctap_mode_e'(cfg_q[0]);
  assign en      = cfg_q[N_CORES:1];
  assign ref_fld = cfg_q[CW-1:N_CORES+1];
  // an index past the last core falls back to core 0
  assign ref_idx = (int'(ref_fld) < int'(N_CORES)) ? ref_fld : '0;

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_cfg && update_dr) && !tlr |=> $stable(cfg_q));

  a_r8_cfg_tlr: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (cfg_q == CFG_RST));

endmodule

// File: rtl/mctap_chain.sv
module mctap_chain
  import mctap_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mctap_mode_e        mode,
  input  logic [N_CORES-1:0] en,
  input  logic [IDX_W-1:0]   ref_idx,
  input  logic               sel_cfg,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               tdi,
  input  logic [N_CORES-1:0] core_tdo,
  output logic [N_CORES-1:0] core_tdi,
  output logic               tdo_data
);

  logic [N_CORES-1:0] link_in;
  logic [N_CORES-1:0] seg_out;
  logic [N_CORES-1:0] byp_q, byp_d;
  logic               carry;

  // serial link: each segment is the core path or its one-bit bypass
  always_comb begin
    carry = tdi;
    for (int i = 0; i < N_CORES; i++) begin
      link_in[i] = carry;
      seg_out[i] = en[i] ? core_tdo[i] : byp_q[i];
      carry      = seg_out[i];
    end
  end

  always_comb begin
    byp_d = byp_q;
    if (!sel_cfg) begin
      if (capture_dr)    byp_d = '0;
      else if (shift_dr) byp_d = link_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= '0;
    else        byp_q <= byp_d;
  end

  assign core_tdi = (mode == MODE_CONC) ? {N_CORES{tdi}} : link_in;
  assign tdo_data = (mode == MODE_CONC) ? core_tdo[ref_idx] : seg_out[N_CORES-1];

  a_r4_byp_capture_zero: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr && !sel_cfg |=> (byp_q == '0));

endmodule

// File: rtl/mctap_misr.sv
module mctap_misr
  import mctap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed,
  input  logic             step,
  input  logic             din,
  output logic [SIG_W-1:0] sig
);

  logic [SIG_W-1:0] sig_q, sig_d;

  always_comb begin
    sig_d = sig_q;
    if (seed)      sig_d = '0;
    else if (step) sig_d = sig_step(sig_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig = sig_q;

  a_r9_seed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (sig_q == '0));

endmodule

// File: rtl/mctap_judge.sv
module mctap_judge
  import mctap_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tlr,
  input  mctap_mode_e        mode,
  input  logic [N_CORES-1:0] en,
  input  logic [IDX_W-1:0]   ref_idx,
  input  logic               sel_cfg,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic [N_CORES-1:0] core_tdo,
  output logic [N_CORES-1:0] fail
);

  logic               active;
  logic [SIG_W-1:0]   sig [N_CORES];
  logic [SIG_W-1:0]   ref_sig;
  logic [N_CORES-1:0] mismatch;
  logic [N_CORES-1:0] fail_q, fail_d;

  assign active = (mode == MODE_CONC) && !sel_cfg;

  for (genvar g = 0; g < N_CORES; g++) begin : g_lane
    mctap_misr u_misr (
      .clk  (clk),
      .rst_n(rst_n),
      .seed (active && capture_dr),
      .step (active && shift_dr && en[g]),
      .din  (core_tdo[g]),
      .sig  (sig[g])
    );

    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q[g] && !tlr |=> fail_q[g]);

    a_r7_masked_never_fails: assert property (@(posedge clk) disable iff (!rst_n)
      !fail_q[g] && !en[g] |=> !fail_q[g]);
  end

  assign ref_sig = sig[ref_idx];

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      mismatch[i] = en[i] && (sig[i] != ref_sig);
    end
  end

  always_comb begin
    fail_d = fail_q;
    if (tlr)                    fail_d = '0;
    else if (active && update_dr) fail_d = fail_q | mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= '0;
    else        fail_q <= fail_d;
  end

  assign fail = fail_q;

  a_r8_tlr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (fail_q == '0));

  a_r10_serial_no_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SERIAL) && !tlr |=> $stable(fail_q));

endmodule

// File: rtl/mctap_hub.sv
module mctap_hub
  import mctap_pkg::*;
#(
  parameter int unsigned N_CORES = 4
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tlr,
  input  logic               sel_cfg,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               tdi,
  output logic               tdo,
  output logic [N_CORES-1:0] core_tdi,
  output logic [N_CORES-1:0] core_shift,
  output logic [N_CORES-1:0] core_capture,
  input  logic [N_CORES-1:0] core_tdo,
  output logic [N_CORES-1:0] core_fail
);

  localparam int unsigned IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic [1:0]         rst_sync;
  logic               rst_n;
  mctap_mode_e        mode;
  logic [N_CORES-1:0] en;
  logic [IDX_W-1:0]   ref_idx;
  logic               tdo_cfg, tdo_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  mctap_cfg #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_cfg (
    .clk       (tck),
    .rst_n     (rst_n),
    .tlr       (tlr),
    .sel_cfg   (sel_cfg),
    .capture_dr(capture_dr),
    .shift_dr  (shift_dr),
    .update_dr (update_dr),
    .tdi       (tdi),
    .tdo_cfg   (tdo_cfg),
    .mode      (mode),
    .en        (en),
    .ref_idx   (ref_idx)
  );

  mctap_chain #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_chain (
    .clk       (tck),
    .rst_n     (rst_n),
    .mode      (mode),
    .en        (en),
    .ref_idx   (ref_idx),
    .sel_cfg   (sel_cfg),
    .capture_dr(capture_dr),
    .shift_dr  (shift_dr),
    .tdi       (tdi),
    .core_tdo  (core_tdo),
    .core_tdi  (core_tdi),
    .tdo_data  (tdo_data)
  );

  mctap_judge #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_judge (
    .clk       (tck),
    .rst_n     (rst_n),
    .tlr       (tlr),
    .mode      (mode),
    .en        (en),
    .ref_idx   (ref_idx),
    .sel_cfg   (sel_cfg),
    .capture_dr(capture_dr),
    .shift_dr  (shift_dr),
    .update_dr (update_dr),
    .core_tdo  (core_tdo),
    .fail      (core_fail)
  );

  assign core_shift   = {N_CORES{shift_dr   && !sel_cfg}} & en;
  assign core_capture = {N_CORES{capture_dr && !sel_cfg}} & en;
  assign tdo          = sel_cfg ? tdo_cfg : tdo_data;

  a_r7_strobes_masked: assert property (@(posedge tck) disable iff (!rst_n)
    ((core_shift | core_capture) & ~en) == '0);

endmodule

// File: tb/mctap_hub_tb_top.sv
module mctap_hub_tb_top;

  localparam int N  = 4;
  localparam int L  = 4;           // core path length in the models
  localparam int CW = 1 + N + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;            // 250 MHz

  logic         trst_n, tlr, sel_cfg, cap, shf, upd, tdi;
  logic         tdo;
  logic [N-1:0] core_tdi, core_shift, core_capture, core_tdo, core_fail;
  logic [N-1:0] fault;
  logic [L-1:0] cq [N];

  mctap_hub #(.N_CORES(N)) dut_i (
    .tck(clk), .trst_n(trst_n), .tlr(tlr), .sel_cfg(sel_cfg),
    .capture_dr(cap), .shift_dr(shf), .update_dr(upd), .tdi(tdi), .tdo(tdo),
    .core_tdi(core_tdi), .core_shift(core_shift), .core_capture(core_capture),
    .core_tdo(core_tdo), .core_fail(core_fail)
  );

  // identical core models: plain shift registers, cleared on capture
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (core_capture[i])    cq[i] <= '0;
      else if (core_shift[i]) cq[i] <= {core_tdi[i], cq[i][L-1:1]};
    end
  end
  always_comb begin
    for (int i = 0; i < N; i++) core_tdo[i] = cq[i][0] ^ fault[i];
  end

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    bit    val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  logic [CW-1:0] cur_cfg = 7'b00_1111_0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare tdo against the scoreboard in the middle of low phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(tdo === e.val, e.tag, {31'd0, tdo}, {31'd0, e.val});
      end
    end
  end

  task automatic cyc(input bit c, input bit s, input bit u, input bit sc, input bit d);
    @(negedge clk);
    cap = c; shf = s; upd = u; sel_cfg = sc; tdi = d; tlr = 1'b0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic write_cfg(input bit m, input logic [N-1:0] e, input logic [1:0] r);
    logic [CW-1:0] w;
    w = {r, e, m};
    cyc(1, 0, 0, 1, 0);
    for (int k = 0; k < CW; k++) begin
      cyc(0, 1, 0, 1, w[k]);
      sb_q.push_back('{val: cur_cfg[k], tag: "R2 cfg readback"});
    end
    cyc(0, 0, 1, 1, 0);
    cur_cfg = w;
    idle();
  endtask

  task automatic scan(input logic [63:0] pat, input int n, input int dly, input bit inv,
                      input logic [N-1:0] exp_en, input string tag);
    cyc(1, 0, 0, 0, 0);
    #1;
    check(core_capture === exp_en, {tag, " R7 capture strobes"}, 32'(core_capture), 32'(exp_en));
    for (int t = 0; t < n; t++) begin
      cyc(0, 1, 0, 0, pat[t]);
      sb_q.push_back('{val: (t < dly) ? inv : (pat[t-dly] ^ inv), tag: tag});
      if (t == 0) begin
        #1;
        check(core_shift === exp_en, {tag, " R7 shift strobes"}, 32'(core_shift), 32'(exp_en));
      end
    end
    cyc(0, 0, 1, 0, 0);
    idle();
  endtask

  task automatic pulse_tlr();
    @(negedge clk);
    cap = 0; shf = 0; upd = 0; sel_cfg = 0; tdi = 0; tlr = 1'b1;
    idle();
    cur_cfg = 7'b00_1111_0;
  endtask

  task automatic check_fail(input logic [N-1:0] expv, input string tag);
    #1;
    check(core_fail === expv, tag, 32'(core_fail), 32'(expv));
  endtask

  localparam logic [63:0] PAT_A = 64'hC3A5_96E1_7B0D_24F8;
  localparam logic [63:0] PAT_B = 64'h5E21_B7C9_0AF3_6D84;

  initial begin
    trst_n = 0; tlr = 0; sel_cfg = 0; cap = 0; shf = 0; upd = 0; tdi = 0; fault = '0;
    repeat (3) @(negedge clk);
    trst_n = 1;
    repeat (4) idle();

    // R1: reset state
    check_fail('0, "R1 fail after reset");
    check(core_shift === '0 && core_capture === '0, "R1 strobes idle", 32'(core_shift), 0);

    // R1/R2: readback of the reset word while writing serial, all enabled
    write_cfg(1'b0, 4'b1111, 2'd0);

    // R3: full chain, four cores of four stages
    scan(PAT_A, 40, 16, 1'b0, 4'b1111, "R3 serial all cores");

    // R4: cores 0 and 2 bypassed
    write_cfg(1'b0, 4'b1010, 2'd0);
    scan(PAT_B, 30, 10, 1'b0, 4'b1010, "R4 serial alternate bypass");

    // R4: every core bypassed -> N zero stages
    write_cfg(1'b0, 4'b0000, 2'd0);
    scan(PAT_A, 20, 4, 1'b0, 4'b0000, "R4 serial all bypass");

    // R10: serial update with a faulty last core
    write_cfg(1'b0, 4'b1111, 2'd0);
    fault = 4'b1000;
    scan(PAT_B, 24, 16, 1'b1, 4'b1111, "R10 serial faulty tail");
    check_fail('0, "R10 serial update ignored");
    fault = '0;

    // R5/R6: concurrent, clean
    write_cfg(1'b1, 4'b1111, 2'd0);
    scan(PAT_A, 32, L, 1'b0, 4'b1111, "R5 concurrent ref0");
    check_fail('0, "R6 clean concurrent");

    // R6: faulty non-reference core
    fault = 4'b0010;
    scan(PAT_B, 32, L, 1'b0, 4'b1111, "R5 concurrent ref0 fault1");
    check_fail(4'b0010, "R6 core1 mismatch");

    // R5/R6: reference moved to a faulty core 2
    fault = 4'b0100;
    write_cfg(1'b1, 4'b1111, 2'd2);
    scan(PAT_A, 32, L, 1'b1, 4'b1111, "R5 concurrent ref2 output");
    check_fail(4'b1011, "R6 sticky plus ref2 mismatches");

    // R8: reset strobe
    pulse_tlr();
    check_fail('0, "R8 tlr clears fail");
    fault = 4'b1000;
    write_cfg(1'b1, 4'b0111, 2'd1);   // readback expects reset word (R8)

    // R7: disabled faulty core 3
    scan(PAT_B, 32, L, 1'b0, 4'b0111, "R5 concurrent ref1");
    check_fail('0, "R7 masked core not flagged");

    // R9: faulty test, tlr, then clean test must compare equal
    fault = 4'b0010;
    write_cfg(1'b1, 4'b1111, 2'd0);
    scan(PAT_A, 32, L, 1'b0, 4'b1111, "R9 first test");
    check_fail(4'b0010, "R9 first test flags core1");
    pulse_tlr();
    fault = '0;
    write_cfg(1'b1, 4'b1111, 2'd0);
    scan(PAT_A, 32, L, 1'b0, 4'b1111, "R9 second test");
    check_fail('0, "R9 reseeded signatures agree");

    repeat (3) idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule